// File: doc/BRIEF.md
# Streaming Zero-Terminated String Comparator

This block orders two zero-terminated byte strings, the way a C library string compare does, while both strings stream in as 16-byte slices. A start pulse arms the engine. After that it takes one slice of each string per accepted handshake and checks all sixteen byte positions at once. A position stops the scan when the two bytes differ, or when the first string holds the zero terminator there. If a slice has no stopping position, the engine adds 16 to its running byte count and waits for the next slice.

At the first stopping position the engine raises a one-cycle done pulse. With it come two values. The first is a 32-bit ordering value: the string-1 byte minus the string-2 byte, both taken as unsigned. It is zero when both strings end together, negative when string 1 orders first, and positive otherwise. The second is the byte offset of the stopping position from the start of the strings. Slices need no alignment, so the source can hand over any 16 consecutive bytes. Bytes after the stopping position inside the final slice have no effect. Once a result is out, the engine refuses further slices until the next start pulse.

Top module: `zstr_compare`

## Requirements
- R1: While reset is held, and after it is released, chunk_ready, done, result and offset are all 0 until the first start pulse.
- R2: The cycle after a start pulse, chunk_ready is 1 and the running byte count is back at 0.
- R3: If an accepted slice pair has no stopping lane, no done is produced, and the byte count grows by exactly 16 for every such slice.
- R4: Lane i occupies bits [8i+7:8i] of each slice, and lane 0 holds the earliest byte. The scan stops at the lowest-numbered lane where the two bytes differ or the string-1 byte is zero. Bytes in higher lanes have no effect.
- R5: At a differing lane, result equals the string-1 byte minus the string-2 byte, both zero-extended to 32 bits, as a two's-complement value. Bytes at 0x80 and above count as large positive values.
- R6: When both strings hold the terminator at the stopping lane, result is 0.
- R7: A terminator in only one of the two strings counts as a difference, so a proper prefix orders before the longer string (a negative result when string 1 is the shorter one).
- R8: done is high for exactly one cycle, in the cycle after the slice that holds the stopping lane is accepted. In that same cycle, offset equals 16 times the number of earlier slices plus the stopping lane.
- R9: From the done cycle until the next start pulse, chunk_ready is 0. Any slices offered in that time leave done, result and offset unchanged.
- R10: A cycle with chunk_valid low transfers no slice and does not move the byte count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle pulse that begins a new comparison |
| chunk_valid | input | 1 | A slice pair is on str_a and str_b |
| chunk_ready | output | 1 | The engine accepts a slice pair this cycle |
| str_a | input | 128 | 16 bytes of string 1, lane 0 in the low byte |
| str_b | input | 128 | 16 bytes of string 2, lane 0 in the low byte |
| done | output | 1 | One-cycle pulse marking a new result |
| result | output | 32 | Ordering value, two's complement |
| offset | output | 32 | Byte offset of the stopping position |

## Verification
Equal strings and strings that differ only in their last byte separate the shared-terminator zero from a real difference. A string against its own prefix, tried in both orders, shows that a lone terminator counts as a difference and that the sign follows which string is shorter. Strings that run across several slices, with idle gaps in the handshake, test the 16-byte stepping and show that idle cycles do not advance the count. A difference in lane 15, bytes at 0x80 and above, empty strings, and garbage that differs after the terminator test the lane priority, the unsigned subtraction and the lanes that must be ignored. After each result, extra slices are offered to show the engine stays closed.

// File: rtl/zstr_pkg.sv
package zstr_pkg;

  localparam int unsigned BYTE_W = 8;
  localparam int unsigned RES_W  = 32;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SCAN = 2'd1,
    ST_HOLD = 2'd2
  } scan_state_e;

  // A lane stops the scan on a mismatch or on the string-1 terminator.
  function automatic logic lane_stop(input logic [BYTE_W-1:0] x,
                                     input logic [BYTE_W-1:0] y);
    return (x != y) || (x == '0);
  endfunction

  // Ordering value: both bytes widened without sign, then subtracted.
  function automatic logic [RES_W-1:0] order_diff(input logic [BYTE_W-1:0] x,
                                                  input logic [BYTE_W-1:0] y);
    logic [RES_W-1:0] wx;
    logic [RES_W-1:0] wy;
    wx = RES_W'(x);
    wy = RES_W'(y);
    return wx - wy;
  endfunction

endpackage

// File: rtl/zstr_lane_cmp.sv
module zstr_lane_cmp #(
  parameter int unsigned LANES = 16
) (
  input  logic [LANES*zstr_pkg::BYTE_W-1:0] slice_a,
  input  logic [LANES*zstr_pkg::BYTE_W-1:0] slice_b,
  output logic [LANES-1:0]                  lane_flag
);
  localparam int unsigned BW = zstr_pkg::BYTE_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_flag[g] = zstr_pkg::lane_stop(slice_a[g*BW +: BW], slice_b[g*BW +: BW]);
  end

endmodule

// File: rtl/zstr_first_find.sv
module zstr_first_find #(
  parameter int unsigned LANES = 16,
  localparam int unsigned IDX_W = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic [LANES-1:0] lane_flag,
  output logic             hit_any,
  output logic [IDX_W-1:0] hit_lane
);

  // Walk from the top so the lowest flagged lane is written last.
  always_comb begin
    hit_any  = 1'b0;
    hit_lane = '0;
    for (int i = LANES - 1; i >= 0; i--) begin
      if (lane_flag[i]) begin
        hit_any  = 1'b1;
        hit_lane = IDX_W'(i);
      end
    end
  end

endmodule

// File: rtl/zstr_ctrl.sv
module zstr_ctrl #(
  parameter int unsigned LANES = 16,
  parameter int unsigned OFF_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             chunk_valid,
  input  logic             hit_any,
  output logic             chunk_ready,
  output logic             accept,
  output logic             finish,
  output logic [OFF_W-1:0] chunk_base
);
  import zstr_pkg::*;

  localparam logic [OFF_W-1:0] STEP = OFF_W'(LANES);

  scan_state_e state_q;

  assign chunk_ready = (state_q == ST_SCAN);
  assign accept      = chunk_valid && chunk_ready;
  assign finish      = accept && hit_any;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      chunk_base <= '0;
    end else if (start) begin
      state_q    <= ST_SCAN;
      chunk_base <= '0;
    end else if (finish) begin
      state_q    <= ST_HOLD;
    end else if (accept) begin
      chunk_base <= chunk_base + STEP;
    end
  end

endmodule

// File: rtl/zstr_compare.sv
module zstr_compare #(
  parameter int unsigned LANES = 16,
  parameter int unsigned OFF_W = 32,
  localparam int unsigned BW     = zstr_pkg::BYTE_W,
  localparam int unsigned DATA_W = LANES * BW,
  localparam int unsigned IDX_W  = (LANES > 1) ? $clog2(LANES) : 1,
  localparam int unsigned RES_W  = zstr_pkg::RES_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              chunk_valid,
  output logic              chunk_ready,
  input  logic [DATA_W-1:0] str_a,
  input  logic [DATA_W-1:0] str_b,
  output logic              done,
  output logic [RES_W-1:0]  result,
  output logic [OFF_W-1:0]  offset
);

  logic [LANES-1:0] lane_flag;
  logic             hit_any;
  logic [IDX_W-1:0] hit_lane;
  logic             accept;
  logic             finish;
  logic [OFF_W-1:0] chunk_base;
  logic [BW-1:0]    pick_a;
  logic [BW-1:0]    pick_b;

  zstr_lane_cmp #(.LANES(LANES)) lane_cmp_i (
    .slice_a  (str_a),
    .slice_b  (str_b),
    .lane_flag(lane_flag)
  );

  zstr_first_find #(.LANES(LANES)) first_find_i (
    .lane_flag(lane_flag),
    .hit_any  (hit_any),
    .hit_lane (hit_lane)
  );

  zstr_ctrl #(.LANES(LANES), .OFF_W(OFF_W)) ctrl_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .chunk_valid(chunk_valid),
    .hit_any    (hit_any),
    .chunk_ready(chunk_ready),
    .accept     (accept),
    .finish     (finish),
    .chunk_base (chunk_base)
  );

  assign pick_a = str_a[int'(hit_lane)*BW +: BW];
  assign pick_b = str_b[int'(hit_lane)*BW +: BW];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done   <= 1'b0;
      result <= '0;
      offset <= '0;
    end else begin
      done <= finish;
      if (finish) begin
        result <= zstr_pkg::order_diff(pick_a, pick_b);
        offset <= chunk_base + OFF_W'(hit_lane);
      end
    end
  end

endmodule

// File: rtl/zstr_compare_chk.sv
module zstr_compare_chk #(
  parameter int unsigned LANES = 16,
  parameter int unsigned OFF_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             chunk_ready,
  input logic             done,
  input logic [31:0]      result,
  input logic             accept,
  input logic             hit_any,
  input logic [OFF_W-1:0] chunk_base
);

  p_ready_after_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> chunk_ready);

  p_base_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !hit_any && !start) |=> (chunk_base == $past(chunk_base) + OFF_W'(LANES)));

  p_base_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!accept && !start) |=> $stable(chunk_base));

  p_result_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($signed(result) <= 255 && $signed(result) >= -255));

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_after_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(accept && hit_any));

  p_closed_at_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !$past(start)) |-> !chunk_ready);

  p_stay_closed_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!chunk_ready && !start) |=> !chunk_ready);

  p_hold_result_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!chunk_ready && !start) |=> $stable(result));

endmodule

bind zstr_compare zstr_compare_chk #(.LANES(LANES), .OFF_W(OFF_W)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .start      (start),
  .chunk_ready(chunk_ready),
  .done       (done),
  .result     (result),
  .accept     (accept),
  .hit_any    (hit_any),
  .chunk_base (chunk_base)
);

// File: tb/zstr_compare_tb_top.sv
module zstr_compare_tb_top;

  localparam int LANES = 16;
  localparam int BUF_N = 256;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic         chunk_valid = 1'b0;
  logic         chunk_ready;
  logic [127:0] str_a = '0;
  logic [127:0] str_b = '0;
  logic         done;
  logic [31:0]  result;
  logic [31:0]  offset;

  int errors = 0;
  int checks = 0;
  int dones_expected = 0;
  int dones_seen = 0;

  logic [7:0] buf_a [BUF_N];
  logic [7:0] buf_b [BUF_N];

  int    q_res [$];
  int    q_off [$];
  string q_tag [$];

  always #2 clk = ~clk;

  zstr_compare dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .chunk_valid(chunk_valid),
    .chunk_ready(chunk_ready),
    .str_a      (str_a),
    .str_b      (str_b),
    .done       (done),
    .result     (result),
    .offset     (offset)
  );

  task automatic check(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  // Bytes after the terminator are junk that differs between the strings.
  task automatic fill(input string s1, input string s2);
    for (int i = 0; i < BUF_N; i++) begin
      buf_a[i] = (i < s1.len()) ? s1[i] : ((i == s1.len()) ? 8'h00 : 8'hAA);
      buf_b[i] = (i < s2.len()) ? s2[i] : ((i == s2.len()) ? 8'h00 : 8'h55);
    end
  endtask

  // Scoreboard monitor: pops one expected item per done pulse.
  always @(negedge clk) begin
    if (rst_n && done) begin
      dones_seen++;
      if (q_res.size() == 0) begin
        check(1'b0, "R8 unexpected done", 1, 0);
      end else begin
        int    er;
        int    eo;
        string tg;
        er = q_res.pop_front();
        eo = q_off.pop_front();
        tg = q_tag.pop_front();
        check($signed(result) == er, {tg, " result"}, $signed(result), er);
        check($signed(offset) == eo, {"R8 ", tg, " offset"}, $signed(offset), eo);
      end
    end
  end

  // Driver: computes the expected item, then streams the slices.
  task automatic run_case(input string tag, input bit gaps);
    int stop_at;
    int exp_res;
    int n_chunks;
    stop_at = BUF_N - 1;
    for (int j = 0; j < BUF_N; j++) begin
      if (buf_a[j] !== buf_b[j] || buf_a[j] == 8'h00) begin
        stop_at = j;
        break;
      end
    end
    exp_res = int'(buf_a[stop_at]) - int'(buf_b[stop_at]);
    q_res.push_back(exp_res);
    q_off.push_back(stop_at);
    q_tag.push_back(tag);
    dones_expected++;
    n_chunks = stop_at / LANES + 1;

    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(chunk_ready == 1'b1, "R2 ready after start", int'(chunk_ready), 1);

    for (int k = 0; k < n_chunks; k++) begin
      if (gaps) begin
        chunk_valid = 1'b0;
        str_a = '0;
        str_b = '0;
        @(negedge clk);
        @(negedge clk);
        check(done == 1'b0, "R10 idle cycle gives no done", int'(done), 0);
      end
      for (int i = 0; i < LANES; i++) begin
        str_a[i*8 +: 8] = buf_a[k*LANES + i];
        str_b[i*8 +: 8] = buf_b[k*LANES + i];
      end
      chunk_valid = 1'b1;
      @(negedge clk);
      if (k < n_chunks - 1)
        check(done == 1'b0, "R3 no done on clean slice", int'(done), 0);
    end
    chunk_valid = 1'b0;

    // Offer a terminating slice while closed: nothing may change.
    str_a = {16{8'h41}};
    str_b = {16{8'h42}};
    chunk_valid = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check(chunk_ready == 1'b0, "R9 ready stays low", int'(chunk_ready), 0);
    check(done == 1'b0, "R9 no extra done", int'(done), 0);
    check($signed(result) == exp_res, "R9 result held", $signed(result), exp_res);
    check($signed(offset) == stop_at, "R9 offset held", $signed(offset), stop_at);
    chunk_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic main_seq();
    repeat (3) @(negedge clk);
    check(chunk_ready == 1'b0 && done == 1'b0, "R1 reset outputs", int'(chunk_ready), 0);
    rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check(chunk_ready == 1'b0, "R1 ready low before start", int'(chunk_ready), 0);
    check(result == 32'd0 && offset == 32'd0, "R1 result offset zero", int'(result), 0);

    fill("apple", "apple");
    run_case("R6 equal short", 1'b0);
    fill("apple", "apply");
    run_case("R5 differ last", 1'b0);
    fill("abc", "abcd");
    run_case("R7 prefix first", 1'b0);
    fill("abcd", "abc");
    run_case("R7 prefix second", 1'b0);
    fill("", "");
    run_case("R6 both empty", 1'b0);
    fill("", "a");
    run_case("R7 empty vs a", 1'b0);
    fill("The quick brown fox jumps over the lazy dog!",
         "The quick brown fox jumps over the lazy dog!");
    run_case("R3 multi slice equal", 1'b0);
    fill("The quick brown fox jumps over the lazy dog!",
         "The quick brown fox jumps over the lazy cat!");
    run_case("R10 gaps multi slice", 1'b1);
    fill("xxxxxxxxxxxxxxxxxxxxxxxxxxxxxxxA", "xxxxxxxxxxxxxxxxxxxxxxxxxxxxxxxB");
    run_case("R4 lane 15 slice 1", 1'b0);
    fill("q12345", "q12345");
    buf_a[3] = 8'hF0;
    buf_b[3] = 8'h10;
    run_case("R5 high byte unsigned", 1'b0);
    fill("q12345", "q12345");
    buf_a[2] = 8'h05;
    buf_b[2] = 8'hFF;
    run_case("R5 high byte negative", 1'b0);
    fill("ab", "ab");
    buf_a[1] = 8'h00;
    buf_b[1] = 8'h00;
    buf_a[5] = 8'h01;
    run_case("R4 lanes past stop ignored", 1'b0);

    repeat (2) @(negedge clk);
    check(dones_seen == dones_expected, "R8 done count", dones_seen, dones_expected);
    check(q_res.size() == 0, "R8 scoreboard drained", q_res.size(), 0);
  endtask

  initial begin
    fork
      main_seq();
      begin
        repeat (100000) @(posedge clk);
        check(1'b0, "watchdog expired", 1, 0);
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule